// File: doc/BRIEF.md
# Completion-Timeout Error Injector

This block lets software raise a test error on one PCI Express port. It has two registers on a small configuration read/write port. The first is a fixed, read-only capability header that identifies the injector. The second is a control word with two bits that matter: an inject-request bit and a disable bit.

When software writes the request bit from 0 to 1, the block produces a single error pulse. The pulse is ORed into the port's live error signal, so logic further down sees it exactly as it would see a real completion-timeout error. If the request bit stays at 1, nothing more happens. Software has to clear the bit and set it again to inject another error. While the disable bit is set, the injector is blocked. A pulse that was blocked is dropped and never delivered later.

Reads are combinational from the offset. The writes that software issues update the register at the next clock edge.

Top module: `errinj_ctl`

## Requirements
- R1: A read at offset 0x1D4 returns the header word 0x00A10003. In that word, bits 31:20 hold the length 0xA, bits 19:16 hold the revision 0x1 and bits 15:0 hold the identifier 0x0003.
- R2: A write at offset 0x1D4 has no effect, and the header still reads 0x00A10003 afterwards.
- R3: A read at offset 0x1D8 returns the stored request bit at bit 2 and the stored disable bit at bit 0. Every other bit reads 0, whatever value was written to it.
- R4: A write at 0x1D8 with bit 2 = 1 and bit 0 = 0, made while the stored request bit is 0, drives `err_o` high for exactly one clock cycle. That cycle is the one that follows the write's clock edge.
- R5: Writing bit 2 = 1 while the stored request bit is already 1 produces no pulse. Holding the bit at 1 never creates a lasting error level.
- R6: After bit 2 has been written back to 0, a new 0-to-1 write produces a new pulse.
- R7: No pulse is produced while the stored disable bit is 1, or when bit 0 = 1 is written in the same write that sets bit 2. The request bit is still stored as 1, so clearing the disable bit later produces no delayed pulse.
- R8: `err_o` is the OR of `hw_err_i` and the injected pulse.
- R9: A read at any offset other than 0x1D4 and 0x1D8 returns 0. A write at such an offset changes no state.
- R10: Synchronous active-high `rst` clears both control bits and any pending pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 12 | Configuration byte offset |
| cfg_wdata | input | 32 | Write data |
| cfg_we | input | 1 | Write strobe, sampled on the clock edge |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| hw_err_i | input | 1 | Live error from the port's own logic |
| err_o | output | 1 | Combined error output, sent on to error reporting |

## Verification
On every cycle, the assertions check the following:
- the pulse never lasts more than one cycle;
- a pulse only follows a fresh rise of the stored request bit while the injector is enabled;
- the disable bit blocks the pulse;
- `err_o` always carries `hw_err_i`;
- the header and the reserved bits read back as constants.

Only the bench scenarios can show the sequences that matter over several writes: clear-then-set re-arming, the absence of a delayed pulse once the disable bit is cleared, that header writes and unmapped writes are ignored, and that reset cancels the register state.

// File: rtl/errinj_ctl.sv
module errinj_ctl #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] HDR_OFS = 12'h1D4,
  parameter logic [ADDR_W-1:0] CTL_OFS = 12'h1D8,
  parameter logic [11:0] CAP_LEN = 12'hA,
  parameter logic [3:0]  CAP_REV = 4'h1,
  parameter logic [15:0] CAP_ID  = 16'h3,
  parameter int REQ_BIT = 2,
  parameter int DIS_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              cfg_we,
  output logic [31:0]       cfg_rdata,
  input  logic              hw_err_i,
  output logic              err_o
);
  localparam logic [31:0] HDR_VAL = {CAP_LEN, CAP_REV, CAP_ID};

  logic cto_q, dis_q, inj_q;
  logic hdr_hit, ctl_hit, wr_ctl, new_req, new_dis, fire;
  logic [31:0] ctl_word;

  assign hdr_hit = (cfg_addr == HDR_OFS);
  assign ctl_hit = (cfg_addr == CTL_OFS);
  assign wr_ctl  = cfg_we && ctl_hit;
  assign new_req = cfg_wdata[REQ_BIT];
  assign new_dis = cfg_wdata[DIS_BIT];
  assign fire    = wr_ctl && new_req && !cto_q && !new_dis;

  always_comb begin
    ctl_word = '0;
    ctl_word[REQ_BIT] = cto_q;
    ctl_word[DIS_BIT] = dis_q;
  end

  assign cfg_rdata = hdr_hit ? HDR_VAL : (ctl_hit ? ctl_word : 32'h0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cto_q <= 1'b0;
      dis_q <= 1'b0;
      inj_q <= 1'b0;
    end else begin
      inj_q <= fire;
      if (wr_ctl) begin
        cto_q <= new_req;
        dis_q <= new_dis;
      end
    end
  end

  assign err_o = hw_err_i | inj_q;

  logic unused_wd;
  assign unused_wd = ^cfg_wdata;
endmodule

module errinj_ctl_chk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] HDR_OFS = 12'h1D4,
  parameter logic [ADDR_W-1:0] CTL_OFS = 12'h1D8,
  parameter logic [31:0] HDR_VAL = 32'h00A10003,
  parameter int REQ_BIT = 2,
  parameter int DIS_BIT = 0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [31:0]       cfg_rdata,
  input logic              hw_err_i,
  input logic              err_o,
  input logic              inj_q,
  input logic              cto_q,
  input logic              dis_q
);
  localparam logic [31:0] CTL_MASK = (32'h1 << REQ_BIT) | (32'h1 << DIS_BIT);

  AST_HDR_CONST: assert property (@(posedge clk) disable iff (rst)
    (cfg_addr == HDR_OFS) |-> (cfg_rdata == HDR_VAL)); // R1
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cfg_addr == CTL_OFS) |-> ((cfg_rdata & ~CTL_MASK) == 32'h0)); // R3
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    inj_q |=> !inj_q); // R4
  AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    inj_q |-> (cto_q && !$past(cto_q))); // R5
  AST_DISABLE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    dis_q |-> !inj_q); // R7
  AST_HW_PASS: assert property (@(posedge clk) disable iff (rst)
    hw_err_i |-> err_o); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (!hw_err_i && !inj_q) |-> !err_o); // R8
endmodule

bind errinj_ctl errinj_ctl_chk #(
  .ADDR_W(ADDR_W), .HDR_OFS(HDR_OFS), .CTL_OFS(CTL_OFS),
  .HDR_VAL({CAP_LEN, CAP_REV, CAP_ID}), .REQ_BIT(REQ_BIT), .DIS_BIT(DIS_BIT)
) u_chk (
  .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .hw_err_i(hw_err_i), .err_o(err_o), .inj_q(inj_q), .cto_q(cto_q), .dis_q(dis_q)
);

// File: tb/errinj_ctl_bench.sv
module errinj_ctl_bench;
  localparam logic [11:0] HDR = 12'h1D4;
  localparam logic [11:0] CTL = 12'h1D8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_rdata;
  logic hw_err_i = 1'b0;
  logic err_o;

  always #10 clk = ~clk;

  errinj_ctl u_errinj_ctl (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .hw_err_i(hw_err_i), .err_o(err_o)
  );

  typedef struct {
    string req;
    bit is_err;
    logic [31:0] exp;
  } item_t;

  item_t sb[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bit m_req = 1'b0, m_dis = 1'b0, m_pend = 1'b0;

  function automatic logic [31:0] model_rd(logic [11:0] a);
    if (a == HDR) return 32'h00A10003;
    if (a == CTL) return {29'h0, m_req, 1'b0, m_dis};
    return 32'h0;
  endfunction

  task automatic step(input string req, input bit r, input logic [11:0] a,
                      input logic [31:0] d, input bit w, input bit h);
    item_t it;
    @(negedge clk);
    rst = r; cfg_addr = a; cfg_wdata = d; cfg_we = w; hw_err_i = h;
    it.req = req; it.is_err = 1'b0; it.exp = model_rd(a);
    sb.push_back(it);
    it.is_err = 1'b1; it.exp = {31'h0, h | m_pend};
    sb.push_back(it);
    if (r) begin
      m_req = 1'b0; m_dis = 1'b0; m_pend = 1'b0;
    end else if (w && a == CTL) begin
      m_pend = d[2] && !m_req && !d[0];
      m_req = d[2];
      m_dis = d[0];
    end else begin
      m_pend = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    #8;
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = it.is_err ? {31'h0, err_o} : cfg_rdata;
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s %s: actual %h expected %h", it.req,
                 it.is_err ? "err_o" : "rdata", act, it.exp);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step("R10", 1, CTL, 0, 0, 0);
    step("R10", 1, HDR, 0, 0, 0);
    step("R1",  0, HDR, 0, 0, 0);
    step("R3",  0, CTL, 0, 0, 0);
    step("R8",  0, 12'h000, 0, 0, 1);
    step("R8",  0, 12'h000, 0, 0, 0);
    step("R4",  0, CTL, 32'h4, 1, 0);
    step("R4",  0, CTL, 0, 0, 0);
    step("R4",  0, CTL, 0, 0, 0);
    step("R5",  0, CTL, 32'h4, 1, 0);
    for (int i = 0; i < 4; i++) step("R5", 0, CTL, 0, 0, 0);
    step("R6",  0, CTL, 32'h0, 1, 0);
    step("R6",  0, CTL, 32'h4, 1, 0);
    step("R8",  0, CTL, 0, 0, 1);
    step("R6",  0, CTL, 0, 0, 0);
    step("R7",  0, CTL, 32'h0, 1, 0);
    step("R7",  0, CTL, 32'h1, 1, 0);
    step("R7",  0, CTL, 32'h5, 1, 0);
    step("R7",  0, CTL, 0, 0, 0);
    step("R7",  0, CTL, 32'h4, 1, 0);
    step("R7",  0, CTL, 0, 0, 0);
    step("R7",  0, CTL, 32'h0, 1, 0);
    step("R7",  0, CTL, 32'h5, 1, 0);
    step("R7",  0, CTL, 32'h4, 1, 0);
    step("R7",  0, CTL, 0, 0, 0);
    step("R2",  0, HDR, 32'hFFFFFFFF, 1, 0);
    step("R2",  0, HDR, 0, 0, 0);
    step("R9",  0, CTL, 32'h0, 1, 0);
    step("R9",  0, 12'h1DC, 32'h4, 1, 0);
    step("R9",  0, CTL, 0, 0, 0);
    step("R9",  0, 12'h100, 0, 0, 0);
    step("R3",  0, CTL, 32'hFFFFFFFA, 1, 0);
    step("R3",  0, CTL, 0, 0, 0);
    step("R3",  0, CTL, 32'hFFFFFFFF, 1, 0);
    step("R3",  0, CTL, 0, 0, 0);
    step("R10", 0, CTL, 32'h0, 1, 0);
    step("R10", 0, CTL, 32'h4, 1, 0);
    step("R10", 1, CTL, 0, 0, 0);
    step("R10", 0, CTL, 0, 0, 0);
    step("R10", 0, CTL, 32'h4, 1, 0);
    step("R10", 0, CTL, 0, 0, 0);
    step("R10", 0, CTL, 0, 0, 0);
    @(negedge clk);
    #12;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule